// File: doc/BRIEF.md
# Multiphase Feedback Divider with Phase-Select Control

This block sits in the feedback path of a clock synthesizer whose oscillator provides ten phases spaced evenly around the cycle. It is modelled at phase-span granularity. Each rising edge of the step clock advances time by one phase span. A nominal feedback period, the oscillator divided by 60, therefore lasts 600 steps. A modulator asks for 0 to 3 phase jumps per period. Each jump moves the selected phase one position forward and shortens that feedback period by one step. Three jumps give a period of 597 steps, which is 0.995 of nominal. This is how the output frequency is pulled down in small, exact amounts.

Several jumps in one period are never merged into one multi-phase leap. They are issued as single-position steps placed evenly through the period, which leaves the largest timing margin around each switch. The selected phase is reported as a 0..9 address. It is also split into a bank choice (even bank holds phases 0,2,4,6,8; odd bank holds 1,3,5,7,9) and a 5:1 sub-address within that bank, to steer a two-level clock multiplexer. A one-step feedback pulse marks the end of every period toward the phase detector.

The jump count arrives on a valid/ready stream. Ready is high only during the last step of each period, which is the pulse step. A transfer happens when valid and ready are both high at a clock edge. The modulator must hold valid and the count stable until that edge; this is the only back-pressure. If valid is low in the pulse step, the next period uses zero jumps. Nothing is buffered.

Top module: `mfd_fb_divider`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to phase address 0 and step 0 of a period with a jump count of 0. In that state fb_pulse and jump_ready are low.
- R2: A period with latched count k lasts exactly 600 − k steps. fb_pulse is high for exactly one step: the last step of each period.
- R3: jump_ready is high exactly in the fb_pulse step. A count offered with jump_valid high in that step is used for the whole next period. If jump_valid is low there, the next period uses 0.
- R4: Within a period with count k, the phase address advances exactly k times, one position per advance, never by more than one at a time.
- R5: Let step 0 be the step after a pulse. For k > 0, advances are triggered at steps floor((600·i + k/2)/k), for i = 0..k−1: steps {0} for k=1, {0,300} for k=2 and {0,200,400} for k=3. The new address is visible from the following step.
- R6: The phase address counts modulo 10: an advance from 9 gives 0.
- R7: bank_odd equals bit 0 of the address (1 = odd bank). bank_sub equals the address shifted right by one (0..4).
- R8: jump_cnt and jump_valid have no effect outside the fb_pulse step. Changing them mid-period leaves period length and advance positions unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock, one edge per phase span |
| rst_n | input | 1 | Synchronous active-low reset |
| jump_valid | input | 1 | Modulator offers a jump count |
| jump_cnt | input | 2 | Requested jumps for the next period (0..3) |
| jump_ready | output | 1 | Block accepts the count this step |
| phase_addr | output | 4 | Selected oscillator phase, 0..9 |
| bank_odd | output | 1 | 2:1 choice, 1 selects the odd bank |
| bank_sub | output | 3 | 5:1 sub-address within the bank |
| fb_pulse | output | 1 | One-step feedback pulse to the phase detector |

## Verification
All outputs are functions of registered state only. fb_pulse and jump_ready are due in step 599 − k of the current period. An advance triggered at step s shows on phase_addr, bank_odd and bank_sub in step s+1. A count accepted at the pulse step governs from step 0 of the next period, one edge later. The bench holds a behavioural model that is advanced by the same inputs at each edge. It compares every output half a clock after the edge. It also measures each period length and counts the advances within it, then checks both against the count the model latched. Between transfers the stream inputs are driven with changing junk to confirm they are ignored.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  // Evenly spread position of the i-th of k single-phase advances
  function automatic int jump_offset(input int steps, input int k, input int i);
    return (steps * i + k / 2) / k;
  endfunction
endpackage

// File: rtl/mfd_period_ctr.sv
module mfd_period_ctr #(
  parameter int STEPS = 600,
  parameter int MAXJ  = 3,
  parameter int CW    = $clog2(STEPS),
  parameter int JW    = $clog2(MAXJ + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          jump_valid,
  input  logic [JW-1:0] jump_cnt,
  output logic [CW-1:0] step_cnt,
  output logic [JW-1:0] k_cur,
  output logic          fb_pulse
);
  logic [JW-1:0] k_in;
  logic [CW-1:0] last_step;

  assign k_in      = (jump_cnt > JW'(MAXJ)) ? JW'(MAXJ) : jump_cnt;
  assign last_step = CW'(STEPS - 1) - CW'(k_cur);
  assign fb_pulse  = rst_n && (step_cnt == last_step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_cnt <= '0;
      k_cur    <= '0;
    end else if (fb_pulse) begin
      step_cnt <= '0;
      k_cur    <= jump_valid ? k_in : '0;
    end else begin
      step_cnt <= step_cnt + 1'b1;
    end
  end

  // R2
  wrap_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> (step_cnt == '0));

  // R8
  count_held_mid_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_pulse |=> $stable(k_cur));

  // R2
  step_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_cnt < CW'(STEPS));
endmodule

// File: rtl/mfd_jump_sched.sv
module mfd_jump_sched #(
  parameter int STEPS = 600,
  parameter int MAXJ  = 3,
  parameter int CW    = $clog2(STEPS),
  parameter int JW    = $clog2(MAXJ + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] step_cnt,
  input  logic [JW-1:0] k_cur,
  output logic          jump_now
);
  logic [MAXJ*MAXJ-1:0] hit;

  for (genvar kk = 1; kk <= MAXJ; kk++) begin : g_cnt
    for (genvar ii = 0; ii < MAXJ; ii++) begin : g_pos
      if (ii < kk) begin : g_used
        localparam int OFF = mfd_pkg::jump_offset(STEPS, kk, ii);
        assign hit[(kk-1)*MAXJ + ii] = (k_cur == JW'(kk)) && (step_cnt == CW'(OFF));
      end else begin : g_unused
        assign hit[(kk-1)*MAXJ + ii] = 1'b0;
      end
    end
  end

  assign jump_now = |hit;

  // R4
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
endmodule

// File: rtl/mfd_phase_sel.sv
module mfd_phase_sel #(
  parameter int NPHASE = 10,
  parameter int AW     = $clog2(NPHASE),
  parameter int SUBW   = $clog2(NPHASE / 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            jump_now,
  output logic [AW-1:0]   phase_addr,
  output logic            bank_odd,
  output logic [SUBW-1:0] bank_sub
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      phase_addr <= '0;
    else if (jump_now)
      phase_addr <= (phase_addr == AW'(NPHASE - 1)) ? '0 : phase_addr + 1'b1;
  end

  assign bank_odd = phase_addr[0];
  assign bank_sub = SUBW'(phase_addr >> 1);

  // R6
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_addr < AW'(NPHASE));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_addr) |->
      (phase_addr == (($past(phase_addr) == AW'(NPHASE - 1)) ? '0 : $past(phase_addr) + 1'b1)));
endmodule

// File: rtl/mfd_fb_divider.sv
module mfd_fb_divider #(
  parameter int NPHASE = 10,
  parameter int DIV    = 60,
  parameter int MAXJ   = 3,
  localparam int STEPS = NPHASE * DIV,
  localparam int CW    = $clog2(STEPS),
  localparam int JW    = $clog2(MAXJ + 1),
  localparam int AW    = $clog2(NPHASE),
  localparam int SUBW  = $clog2(NPHASE / 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            jump_valid,
  input  logic [JW-1:0]   jump_cnt,
  output logic            jump_ready,
  output logic [AW-1:0]   phase_addr,
  output logic            bank_odd,
  output logic [SUBW-1:0] bank_sub,
  output logic            fb_pulse
);
  logic [CW-1:0] step_cnt;
  logic [JW-1:0] k_cur;
  logic          jump_now;

  mfd_period_ctr #(.STEPS(STEPS), .MAXJ(MAXJ), .CW(CW), .JW(JW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .jump_valid(jump_valid), .jump_cnt(jump_cnt),
    .step_cnt(step_cnt), .k_cur(k_cur), .fb_pulse(fb_pulse)
  );

  mfd_jump_sched #(.STEPS(STEPS), .MAXJ(MAXJ), .CW(CW), .JW(JW)) u_sched (
    .clk(clk), .rst_n(rst_n), .step_cnt(step_cnt), .k_cur(k_cur), .jump_now(jump_now)
  );

  mfd_phase_sel #(.NPHASE(NPHASE), .AW(AW), .SUBW(SUBW)) u_sel (
    .clk(clk), .rst_n(rst_n), .jump_now(jump_now),
    .phase_addr(phase_addr), .bank_odd(bank_odd), .bank_sub(bank_sub)
  );

  assign jump_ready = fb_pulse;

  // Advance tally per period, kept for the checks below
  logic [JW:0] adv_seen;
  always_ff @(posedge clk) begin
    if (!rst_n || fb_pulse) adv_seen <= '0;
    else if (jump_now)      adv_seen <= adv_seen + 1'b1;
  end

  // R4
  advances_match_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |-> (adv_seen == {1'b0, k_cur}));

  // R3
  count_taken_at_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_pulse && !jump_valid) |=> (k_cur == '0));
endmodule

// File: tb/mfd_fb_divider_tb.sv
module mfd_fb_divider_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STEPS = 600;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       jump_valid = 1'b0;
  logic [1:0] jump_cnt = 2'd0;
  logic       jump_ready;
  logic [3:0] phase_addr;
  logic       bank_odd;
  logic [2:0] bank_sub;
  logic       fb_pulse;

  int vectors = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfd_fb_divider u_dut (
    .clk(clk), .rst_n(rst_n), .jump_valid(jump_valid), .jump_cnt(jump_cnt),
    .jump_ready(jump_ready), .phase_addr(phase_addr), .bank_odd(bank_odd),
    .bank_sub(bank_sub), .fb_pulse(fb_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_jump(input int c, input int k);
    for (int i = 0; i < k; i++)
      if (c == (STEPS * i + k / 2) / k) return 1'b1;
    return 1'b0;
  endfunction

  // model state
  int m_cnt = 0, m_k = 0, m_addr = 0;
  int per_len = 0, per_adv = 0;
  int last_addr = 0;
  int plan[$] = '{3, 1, -1, 2, 3, 0, 3, 3, 2, 1, 3, -1, 2};

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int idx = 0;
    int mlast;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 addr", phase_addr, 0);
    chk("R1 fb_pulse", fb_pulse, 0);
    chk("R1 ready", jump_ready, 0);
    rst_n = 1'b1;
    last_addr = 0;
    for (int cyc = 0; cyc < 7900; cyc++) begin
      int ent;
      mlast = STEPS - 1 - m_k;
      // compare model against outputs (Moore, sampled mid-cycle)
      chk("R2 fb_pulse", fb_pulse, (m_cnt == mlast) ? 1 : 0);
      chk("R3 ready", jump_ready, (m_cnt == mlast) ? 1 : 0);
      chk("R5 R6 addr", phase_addr, m_addr);
      chk("R7 bank_odd", bank_odd, m_addr % 2);
      chk("R7 bank_sub", bank_sub, m_addr / 2);
      if (phase_addr != last_addr) per_adv++;
      last_addr = phase_addr;
      per_len++;
      if (fb_pulse) begin
        if (cyc > 0) begin
          chk("R2 period length", per_len, STEPS - m_k);
          chk("R4 advances per period", per_adv, m_k);
        end
        per_len = 0;
        per_adv = 0;
      end
      // drive stream inputs for this step
      ent = (idx < plan.size()) ? plan[idx] : -1;
      if (ent >= 0) begin
        jump_valid = 1'b1;
        jump_cnt = 2'(ent);
      end else begin
        // R8: junk while not offering a count
        jump_valid = (cyc % 7 == 3);
        jump_cnt = 2'(cyc % 4);
        if (m_cnt == mlast) jump_valid = 1'b0;
      end
      // advance model to the next edge
      if (m_k > 0 && is_jump(m_cnt, m_k)) m_addr = (m_addr + 1) % 10;
      if (m_cnt == mlast) begin
        m_cnt = 0;
        m_k = jump_valid ? int'(jump_cnt) : 0;
        idx++;
      end else begin
        m_cnt++;
      end
      @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule